// File: doc/BRIEF.md
# Serial Register Slave with Alert Response

This block is the two-wire (I2C/SMBus) slave front end of a gauge chip's register file. It oversamples SCL and SDA on the system clock and pulls SDA low through an open-drain enable. It recognises its own 7-bit address and turns bus traffic into single-cycle read and write strobes on a 24-byte internal register port. The register storage itself lives outside the block. A register pointer is loaded by the first byte of a write transfer. It then steps forward after every data byte written and after every byte the master acknowledges on a read. Reading the status byte raises a clear strobe, so the status logic outside can drop the flags the host has now seen.

The block also owns the alert line. An alert event from the measurement logic pulls the alert output low, but only while the pin is configured as an alert output. The line stays low until the host completes an alert response query. In that query the slave returns its own address and gives way at once if another device wins the bus bit by bit. After a completed response it answers no further queries until a new event arrives.

The FSM states are IDLE, ADDR (address byte shifting in), AACK (address acknowledge), RX (data byte shifting in), RACK (data acknowledge), TX (data byte shifting out), MACK (master acknowledge slot), ARA (alert response byte shifting out) and SKIP (waiting for the next START or STOP). The transitions are as follows. A START sends every state to ADDR, and a STOP sends every state to IDLE. After the eighth address bit, ADDR goes to AACK on a hit and to SKIP otherwise. On the SCL fall that ends the acknowledge, AACK goes to RX, TX or ARA. RX goes to RACK after eight bits, and RACK returns to RX. TX goes to MACK after eight bits. MACK goes back to TX when the master acknowledges and to SKIP when it does not. ARA goes to SKIP after its last bit or on a lost arbitration.

Top module: `i2cs_regslave`

## Requirements
- R1: The slave acknowledges address byte 1100100 with either R/W value. Any other address, apart from an alert query accepted under R8, gets no acknowledge, and the bus is left alone until the next START.
- R2: A write transfer is the own address with R/W=0, then one pointer byte, then data bytes. Each data byte goes out on the write strobe at the current pointer, after which the pointer moves up by one. The slave acknowledges every byte.
- R3: Pointer values 0x00, 0x08, 0x09, 0x0E, 0x0F, 0x14 and 0x15 name read-only registers. Pointer values of 0x18 and above name nothing. Data bytes sent to any of these are acknowledged, but no write strobe is raised.
- R4: A read is a pointer write, a repeated START and the own address with R/W=1. Bytes go out MSB first starting at the pointer. Each master ACK moves the pointer up by one and sends the next register, and a master NACK ends the transfer.
- R5: When the pointer is 0x18 or above, a read returns 0x00 and raises no read strobe.
- R6: Reading the byte at pointer 0x00 (status) raises the status-clear strobe in the same cycle as the read strobe, so a second read returns the cleared value.
- R7: The alert output is set by an alert event only while pin mode is 2'b10. Mode 2'b01 (charge-complete input) and mode 2'b00 (disabled) do not set it. Once set, it stays set through any later mode change.
- R8: The alert query is byte 0x19 (address 0001100, R/W=1). It is acknowledged only while the alert output is set, and the slave then returns 0xC9 (its own address followed by a 1).
- R9: If the slave samples SDA low at an SCL rise while sending a 1 in the alert reply, it stops driving for the rest of that transfer, and the alert output stays set.
- R10: Once all eight reply bits have gone out, the alert output is released. Further alert queries are not acknowledged until a new alert event.
- R11: After reset, SDA and alert are released, no strobe is active and the pointer is 0x00. The write and read strobes never fire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| alert_pull | output | 1 | Open-drain enable: 1 pulls the alert line low |
| pin_mode | input | 2 | Alert pin mode: 10 alert, 01 charge-complete, 00 off |
| alert_event | input | 1 | One-cycle pulse: a threshold or rollover event occurred |
| reg_addr | output | 5 | Register index for the strobes |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is taken that cycle |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational |
| stat_clr | output | 1 | One-cycle strobe: status byte has been read |

## Verification
Every bus edge takes two synchronizer flops plus one edge register to register, and the state register adds one more. So an acknowledge or data bit shows up on sda_pull about four clocks after the SCL fall that asks for it. A lost arbitration or a completed alert reply takes effect within the same few clocks after its SCL edge. The bench drives SCL with phases of eight clocks and samples SDA at the middle of each SCL-high phase, well past that delay. It also checks strobe results (register contents and strobe counts) and the alert output only after the transfer's STOP or a short settling wait, so no check samples a result in the cycle it changes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int REG_COUNT = 24;
    localparam logic [6:0] ARA_ADDR = 7'b0001100;
    localparam logic [1:0] MODE_ALERT = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_MACK,
        ST_ARA,
        ST_SKIP
    } bus_state_t;

    typedef enum logic [1:0] {
        NX_WRITE,
        NX_READ,
        NX_ARA
    } ack_next_t;

    function automatic logic reg_writable(input logic [7:0] idx);
        logic ro;
        ro = (idx == 8'h00) || (idx == 8'h08) || (idx == 8'h09) ||
             (idx == 8'h0E) || (idx == 8'h0F) || (idx == 8'h14) || (idx == 8'h15);
        return (idx < 8'(REG_COUNT)) && !ro;
    endfunction

endpackage

// File: rtl/i2cs_bus_sync.sv
module i2cs_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_last;
    logic              sda_last;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_last <= 1'b1;
            sda_last <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_last <= scl_pipe[STAGES-1];
            sda_last <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_bit   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_now && !scl_last;
    assign scl_fall  = !scl_now && scl_last;
    assign start_det = scl_now && scl_last && sda_last && !sda_bit;
    assign stop_det  = scl_now && scl_last && !sda_last && sda_bit;

endmodule

// File: rtl/i2cs_alert_latch.sv
module i2cs_alert_latch
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alert_event,
    input  logic [1:0] pin_mode,
    input  logic       ara_done,
    output logic       alert_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else if (alert_event && (pin_mode == MODE_ALERT)) begin
            alert_q <= 1'b1;
        end else if (ara_done) begin
            alert_q <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'b1100100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic       alert_pull,
    input  logic [1:0] pin_mode,
    input  logic       alert_event,
    output logic [4:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata,
    output logic       stat_clr
);

    localparam int         ADDR_W    = $clog2(REG_COUNT);
    localparam logic [7:0] PTR_END   = 8'(REG_COUNT);
    localparam logic [7:0] ARA_BYTE  = {ARA_ADDR, 1'b1};
    localparam logic [7:0] REPLY     = {OWN_ADDR, 1'b1};
    localparam logic [3:0] LAST_BIT  = 4'd7;
    localparam logic [3:0] BYTE_DONE = 4'd8;

    logic       scl_rise, scl_fall, sda_bit, start_det, stop_det;
    bus_state_t state, state_nx;
    ack_next_t  kind;
    logic [7:0] shreg, ptr, tx_byte;
    logic [3:0] bitcnt;
    logic       ptr_phase, m_ack, alert_q, ara_done;
    logic       byte_in, own_hit, ara_hit, load_tx, ptr_valid;

    i2cs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_alert_latch u_alert (
        .clk         (clk),
        .rst_n       (rst_n),
        .alert_event (alert_event),
        .pin_mode    (pin_mode),
        .ara_done    (ara_done),
        .alert_q     (alert_q)
    );

    assign byte_in   = scl_fall && (bitcnt == BYTE_DONE);
    assign own_hit   = (shreg[7:1] == OWN_ADDR);
    assign ara_hit   = (shreg == ARA_BYTE) && alert_q;
    assign ptr_valid = (ptr < PTR_END);
    assign tx_byte   = ptr_valid ? reg_rdata : 8'h00;
    assign load_tx   = scl_fall && (((state == ST_AACK) && (kind == NX_READ)) ||
                                    ((state == ST_MACK) && m_ack));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: state_nx = state;
                ST_ADDR: begin
                    if (byte_in) state_nx = (own_hit || ara_hit) ? ST_AACK : ST_SKIP;
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        unique case (kind)
                            NX_WRITE: state_nx = ST_RX;
                            NX_READ:  state_nx = ST_TX;
                            default:  state_nx = ST_ARA;
                        endcase
                    end
                end
                ST_RX:   if (byte_in) state_nx = ST_RACK;
                ST_RACK: if (scl_fall) state_nx = ST_RX;
                ST_TX:   if (scl_fall && (bitcnt == LAST_BIT)) state_nx = ST_MACK;
                ST_MACK: if (scl_fall) state_nx = m_ack ? ST_TX : ST_SKIP;
                ST_ARA: begin
                    if (scl_rise && shreg[7] && !sda_bit) state_nx = ST_SKIP;
                    else if (scl_fall && (bitcnt == LAST_BIT)) state_nx = ST_SKIP;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shift register, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= 8'h00;
            bitcnt    <= 4'd0;
            ptr       <= 8'h00;
            ptr_phase <= 1'b0;
            m_ack     <= 1'b0;
            kind      <= NX_WRITE;
        end else if (start_det) begin
            bitcnt <= 4'd0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise && (bitcnt != BYTE_DONE)) begin
                        shreg  <= {shreg[6:0], sda_bit};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_in) begin
                        if (own_hit) begin
                            kind      <= shreg[0] ? NX_READ : NX_WRITE;
                            ptr_phase <= !shreg[0];
                        end else begin
                            kind <= NX_ARA;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise && (bitcnt != BYTE_DONE)) begin
                        shreg  <= {shreg[6:0], sda_bit};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_in) begin
                        if (ptr_phase) begin
                            ptr       <= shreg;
                            ptr_phase <= 1'b0;
                        end else begin
                            ptr <= ptr + 8'd1;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bitcnt <= 4'd0;
                        if (kind == NX_READ) begin
                            shreg <= tx_byte;
                            ptr   <= ptr + 8'd1;
                        end else if (kind == NX_ARA) begin
                            shreg <= REPLY;
                        end
                    end
                end
                ST_RACK: if (scl_fall) bitcnt <= 4'd0;
                ST_TX, ST_ARA: begin
                    if (scl_fall && (bitcnt != LAST_BIT)) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) m_ack <= !sda_bit;
                    if (load_tx) begin
                        shreg  <= tx_byte;
                        ptr    <= ptr + 8'd1;
                        bitcnt <= 4'd0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        reg_wr   = 1'b0;
        ara_done = 1'b0;
        unique case (state)
            ST_AACK, ST_RACK: sda_pull = 1'b1;
            ST_TX:            sda_pull = !shreg[7];
            ST_ARA: begin
                sda_pull = !shreg[7];
                ara_done = scl_fall && (bitcnt == LAST_BIT) && !start_det && !stop_det;
            end
            ST_RX: reg_wr = byte_in && !ptr_phase && !start_det && !stop_det && reg_writable(ptr);
            default: ;
        endcase
        reg_rd = load_tx && ptr_valid && !start_det && !stop_det;
    end

    assign stat_clr   = reg_rd && (ptr == 8'h00);
    assign reg_addr   = ptr[ADDR_W-1:0];
    assign reg_wdata  = shreg;
    assign alert_pull = alert_q;

endmodule

// File: rtl/i2cs_regslave_chk.sv
module i2cs_regslave_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [4:0] reg_addr,
    input logic       stat_clr,
    input logic       alert_pull,
    input logic       alert_event,
    input logic [1:0] pin_mode,
    input logic       ara_done
);

    a_r3_ro_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_writable({3'b000, reg_addr}));

    a_r5_rd_in_map: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> (reg_addr < 5'd24));

    a_r6_clr_on_status: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> (reg_rd && (reg_addr == 5'd0)));

    a_r7_alert_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_pull && !ara_done) |=> alert_pull);

    a_r7_alert_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_pull) |-> $past(alert_event && (pin_mode == 2'b10)));

    a_r8_reply_needs_alert: assert property (@(posedge clk) disable iff (!rst_n)
        ara_done |-> alert_pull);

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_done && !alert_event) |=> !alert_pull);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

endmodule

bind i2cs_regslave i2cs_regslave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .stat_clr    (stat_clr),
    .alert_pull  (alert_pull),
    .alert_event (alert_event),
    .pin_mode    (pin_mode),
    .ara_done    (ara_done)
);

// File: tb/i2cs_regslave_bench.sv
module i2cs_regslave_bench;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull, alert_pull;
    logic [1:0] pin_mode = 2'b10;
    logic alert_event = 1'b0;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic reg_wr, reg_rd, stat_clr;

    logic [7:0] mem   [0:23];
    logic [7:0] exp_m [0:23];
    logic [7:0] wbuf  [0:7];
    logic [7:0] rbuf  [0:7];
    logic       stat_load = 1'b0;
    logic [7:0] stat_val = 8'h00;
    int wr_count = 0;
    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    i2cs_regslave u_i2cs_regslave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_pull    (sda_pull),
        .alert_pull  (alert_pull),
        .pin_mode    (pin_mode),
        .alert_event (alert_event),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_rdata   (reg_rdata),
        .stat_clr    (stat_clr)
    );

    function automatic logic [7:0] init_val(input int i);
        return (i == 0) ? 8'h00 : 8'(8'h30 + i * 5);
    endfunction

    function automatic logic bench_writable(input int a);
        return (a > 0) && (a < 24) && !(a inside {8, 9, 14, 15, 20, 21});
    endfunction

    always_comb reg_rdata = (reg_addr < 5'd24) ? mem[reg_addr] : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 24; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_wr) begin
                mem[reg_addr] <= reg_wdata;
                wr_count <= wr_count + 1;
            end
            if (stat_clr)  mem[0] <= 8'h00;
            if (stat_load) mem[0] <= stat_val;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic drive, output logic got);
        sda_m = drive;
        wq();
        scl_m = 1'b1;
        wq();
        got = sda_bus;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic xfer_byte(input logic [7:0] out, output logic [7:0] in);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(out[i], b);
            in[i] = b;
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b1;
        wq();
        wq();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ok);
        logic [7:0] junk;
        logic b;
        xfer_byte(d, junk);
        bit_xfer(1'b1, b);
        ok = !b;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] d);
        logic b;
        xfer_byte(8'hFF, d);
        bit_xfer(last, b);
    endtask

    task automatic write_to(input logic [7:0] p, input int n, output logic all_ok);
        logic ok;
        all_ok = 1'b1;
        bus_start();
        wr_byte(8'hC8, ok); all_ok &= ok;
        wr_byte(p, ok);     all_ok &= ok;
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], ok);
            all_ok &= ok;
            if (bench_writable(int'(p) + i)) exp_m[int'(p) + i] = wbuf[i];
        end
        bus_stop();
    endtask

    task automatic read_from(input logic [7:0] p, input int n, output logic all_ok);
        logic ok;
        all_ok = 1'b1;
        bus_start();
        wr_byte(8'hC8, ok); all_ok &= ok;
        wr_byte(p, ok);     all_ok &= ok;
        bus_start();
        wr_byte(8'hC9, ok); all_ok &= ok;
        for (int i = 0; i < n; i++) rd_byte(i == n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic ara_query(input logic [7:0] drive, output logic ack, output logic [7:0] got);
        logic b;
        got = 8'h00;
        bus_start();
        wr_byte(8'h19, ack);
        if (ack) begin
            xfer_byte(drive, got);
            bit_xfer(1'b1, b);
        end
        bus_stop();
    endtask

    task automatic fire_event();
        @(negedge clk) alert_event = 1'b1;
        @(negedge clk) alert_event = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic ok, ack;
        logic [7:0] got;
        int c;
        void'($urandom(32'd2024));
        for (int i = 0; i < 24; i++) exp_m[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 reset state
        chk("R11 sda released", {31'd0, sda_pull}, 0);
        chk("R11 alert released", {31'd0, alert_pull}, 0);
        chk("R11 no strobes", {30'd0, reg_wr, reg_rd}, 0);

        // R1 foreign address is not acknowledged
        c = wr_count;
        bus_start();
        wr_byte(8'hA0, ok);
        bus_stop();
        chk("R1 foreign address nack", {31'd0, ok}, 0);
        chk("R1 foreign no write", c, wr_count);

        // R2 burst write with auto-increment
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        c = wr_count;
        write_to(8'h04, 3, ok);
        chk("R2 all bytes acked", {31'd0, ok}, 1);
        chk("R2 write count", wr_count, c + 3);
        chk("R2 reg4", mem[4], 8'h11);
        chk("R2 reg6", mem[6], 8'h33);

        // R4 burst read with auto-increment
        read_from(8'h04, 3, ok);
        chk("R4 read acked", {31'd0, ok}, 1);
        chk("R4 byte0", rbuf[0], 8'h11);
        chk("R4 byte1", rbuf[1], 8'h22);
        chk("R4 byte2", rbuf[2], 8'h33);

        // R3 read-only and out-of-map writes
        c = wr_count;
        wbuf[0] = 8'h55;
        write_to(8'h09, 1, ok);
        chk("R3 ro write acked", {31'd0, ok}, 1);
        chk("R3 ro no strobe", wr_count, c);
        wbuf[0] = 8'h66; wbuf[1] = 8'h77;
        write_to(8'h18, 2, ok);
        chk("R3 beyond map acked", {31'd0, ok}, 1);
        chk("R3 beyond map no strobe", wr_count, c);
        read_from(8'h09, 1, ok);
        chk("R3 ro unchanged", rbuf[0], exp_m[9]);

        // R5 reads past the map
        read_from(8'h16, 4, ok);
        chk("R5 reg16", rbuf[0], exp_m[22]);
        chk("R5 reg17", rbuf[1], exp_m[23]);
        chk("R5 past end 0", rbuf[2], 8'h00);
        chk("R5 past end 1", rbuf[3], 8'h00);

        // R6 status clears on read
        stat_val = 8'h5B;
        @(negedge clk) stat_load = 1'b1;
        @(negedge clk) stat_load = 1'b0;
        read_from(8'h00, 1, ok);
        chk("R6 status first read", rbuf[0], 8'h5B);
        read_from(8'h00, 1, ok);
        chk("R6 status cleared", rbuf[0], 8'h00);

        // R8 query without alert
        ara_query(8'hFF, ack, got);
        chk("R8 query nack without alert", {31'd0, ack}, 0);

        // R7 mode gating and hold
        pin_mode = 2'b00;
        fire_event();
        chk("R7 disabled mode no alert", {31'd0, alert_pull}, 0);
        pin_mode = 2'b01;
        fire_event();
        chk("R7 charge mode no alert", {31'd0, alert_pull}, 0);
        pin_mode = 2'b10;
        fire_event();
        chk("R7 alert set", {31'd0, alert_pull}, 1);
        pin_mode = 2'b01;
        repeat (10) @(negedge clk);
        chk("R7 alert kept over mode change", {31'd0, alert_pull}, 1);

        // R8 successful reply, R10 release
        ara_query(8'hFF, ack, got);
        chk("R8 query acked", {31'd0, ack}, 1);
        chk("R8 reply byte", got, 8'hC9);
        chk("R10 alert released", {31'd0, alert_pull}, 0);
        ara_query(8'hFF, ack, got);
        chk("R10 second query nack", {31'd0, ack}, 0);

        // R9 lost arbitration
        pin_mode = 2'b10;
        fire_event();
        ara_query(8'h7F, ack, got);
        chk("R9 query acked", {31'd0, ack}, 1);
        chk("R9 slave backed off", got, 8'h7F);
        chk("R9 alert still set", {31'd0, alert_pull}, 1);
        ara_query(8'hFF, ack, got);
        chk("R10 retry reply", got, 8'hC9);
        chk("R10 alert released after retry", {31'd0, alert_pull}, 0);

        // R2/R3/R4 random bursts
        for (int it = 0; it < 16; it++) begin
            int a, n;
            a = 1 + int'($urandom_range(0, 19));
            n = 1 + int'($urandom_range(0, 3));
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_to(8'(a), n, ok);
            chk("R2 random write acked", {31'd0, ok}, 1);
            read_from(8'(a), n, ok);
            for (int k = 0; k < n; k++) chk("R4 R3 random readback", rbuf[k], exp_m[a + k]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule